// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block produces the bus cycles that a 16-bit processor core of the 6502 lineage runs when it takes a hardware interrupt. On a one-cycle request it captures the return state: program counter, program bank, status byte, emulation flag, stack pointer and the vector address chosen by the arbiter. It then runs a fixed series of bus cycles. The series starts with a dummy program read and one internal cycle. It pushes the return state onto the stack, reads the two vector bytes, and ends with the new program counter loaded. The bank is cleared, interrupt-disable is set and decimal mode is cleared.

Each bus cycle states what kind of access it is on two status lines, `vda_o` and `vpa_o`. It also reports how many master clocks it lasts, so a clock generator upstream can stretch the cycle. A small region map sets the cost. Internal cycles and accesses to a fast window cost 6 master clocks. All other accesses cost 8. In emulation mode the bank byte is not pushed. The stacked copy of the status has its break bit cleared, and the stack stays inside page one.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and after its release with no request: `busy_o`=0, `done_o`=0, `rwb_o`=1, `vda_o`=0, `vpa_o`=0.
- R2: The first cycle after an accepted request is a read of address {bank, PC} with `vda_o`=0, `vpa_o`=1. The second cycle is an internal cycle at the same address with `vda_o`=0, `vpa_o`=0.
- R3: In native mode (`emu_i`=0) four writes follow. They store the bank byte, PC[15:8], PC[7:0] and the status byte, in that order, at addresses {0x00, SP}, {0x00, SP-1}, {0x00, SP-2} and {0x00, SP-3}. Every write has `rwb_o`=0, `vda_o`=1, `vpa_o`=0. `rwb_o` is 0 in no other cycle.
- R4: In emulation mode (`emu_i`=1) the bank write is left out, so there are three writes. The stack pointer's high byte is forced to 0x01 at capture. Each decrement wraps only the low byte, so SP 0x0100 is followed by 0x01FF.
- R5: In emulation mode the stacked status byte has bit 4 (mask 0x10) cleared. In native mode it is stacked as captured.
- R6: After the pushes come two reads with `vda_o`=1, `vpa_o`=0, at {0x00, V} and then at {0x00, V+1 mod 65536}. In the cycle after the second read, `done_o` is 1 for exactly one cycle and `pc_o` equals {byte read second, byte read first}.
- R7: When `done_o` is 1, `pbank_o`=0x00. `psr_o` is then the captured status with bit 2 (interrupt disable) set and bit 3 (decimal) cleared; the other bits are unchanged, break bit included.
- R8: `mclk_o` is 6 for internal cycles. For accesses it is 6 when bank bit 6 is 0 and the 16-bit offset lies in 0x2000..0x5FFF, and 8 otherwise.
- R9: A request raised while `busy_o`=1, including the `done_o` cycle, is ignored. The stacked values and vector come from the first request, and `busy_o` falls after `done_o`.
- R10: When `done_o` is 1, `sp_o` equals the entry SP minus the number of pushes. The subtraction is 16-bit in native mode and wraps within page one in emulation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Interrupt entry request |
| emu_i | input | 1 | Emulation mode flag at request |
| pbank_i | input | 8 | Program bank at request |
| pc_i | input | 16 | Program counter at request |
| psr_i | input | 8 | Status byte at request |
| sp_i | input | 16 | Stack pointer at request |
| vec_i | input | 16 | Vector address in bank 0 |
| din_i | input | 8 | Read data bus |
| addr_o | output | 24 | Address bus {bank, offset} |
| dout_o | output | 8 | Write data bus |
| rwb_o | output | 1 | 1 = read, 0 = write |
| vda_o | output | 1 | Valid data address status |
| vpa_o | output | 1 | Valid program address status |
| mclk_o | output | 4 | Master clocks taken by the current cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Program counter state |
| pbank_o | output | 8 | Program bank state |
| psr_o | output | 8 | Status byte state |
| sp_o | output | 16 | Stack pointer state |

## Verification
The hardest state to reach is a stack decrement that crosses a boundary. In emulation mode the low byte passes from 0x00 to 0xFF while the page must stay at 0x01. In native mode the pointer wraps from 0x0000 to 0xFFFF. The stimulus table therefore places the entry stack pointer two or three pushes above each edge, and gives one emulation case a high byte other than 0x01 to prove the page is forced. A vector at 0xFFFF checks the wrap of the second vector read. A request held high from the first cycle through the done cycle, with a different PC, shows that the capture happens only once.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int PC_W   = 16;
    localparam int BANK_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = BANK_W + PC_W;
    localparam int MCLK_W = 4;

    localparam logic [DATA_W-1:0] BRK_MASK = 8'h10;
    localparam logic [DATA_W-1:0] IRQ_MASK = 8'h04;
    localparam logic [DATA_W-1:0] DEC_MASK = 8'h08;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_DUMMY  = 4'd1,
        S_IO     = 4'd2,
        S_PUSH_B = 4'd3,
        S_PUSH_H = 4'd4,
        S_PUSH_L = 4'd5,
        S_PUSH_P = 4'd6,
        S_VEC_L  = 4'd7,
        S_VEC_H  = 4'd8,
        S_DONE   = 4'd9
    } seq_state_e;

    // encoding is {vda, vpa}
    typedef enum logic [1:0] {
        K_INTERNAL = 2'b00,
        K_PROGRAM  = 2'b01,
        K_DATA     = 2'b10,
        K_OPCODE   = 2'b11
    } bus_kind_e;

    typedef struct packed {
        seq_state_e          state;
        logic                emu;
        logic [BANK_W-1:0]   pbank;
        logic [PC_W-1:0]     pc;
        logic [DATA_W-1:0]   psr;
        logic [PC_W-1:0]     sp;
        logic [PC_W-1:0]     vec;
        logic [DATA_W-1:0]   vlo;
    } seq_ctx_t;
endpackage

// File: rtl/irq_entry_stack.sv
module irq_entry_stack #(
    parameter int              W    = 16,
    parameter logic [W/2-1:0]  PAGE = 'h01
) (
    input  logic         emu_cur,
    input  logic [W-1:0] sp_cur,
    input  logic         emu_new,
    input  logic [W-1:0] sp_new,
    output logic [W-1:0] sp_dec,
    output logic [W-1:0] sp_entry
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] low_dec;

    always_comb begin
        low_dec  = sp_cur[HALF-1:0] - 1'b1;
        sp_dec   = emu_cur ? {PAGE, low_dec} : (sp_cur - 1'b1);
        sp_entry = emu_new ? {PAGE, sp_new[HALF-1:0]} : sp_new;
    end
endmodule

// File: rtl/irq_entry_cost.sv
module irq_entry_cost #(
    parameter int               PC_W     = 16,
    parameter int               MCLK_W   = 4,
    parameter int               IO_CLK   = 6,
    parameter int               FAST_CLK = 6,
    parameter int               SLOW_CLK = 8,
    parameter logic [PC_W-1:0]  FAST_LO  = 16'h2000,
    parameter logic [PC_W-1:0]  FAST_HI  = 16'h5FFF
) (
    input  logic              internal,
    input  logic              high_bank,
    input  logic [PC_W-1:0]   off,
    output logic [MCLK_W-1:0] mclk
);
    localparam logic [MCLK_W-1:0] IO_V   = MCLK_W'(IO_CLK);
    localparam logic [MCLK_W-1:0] FAST_V = MCLK_W'(FAST_CLK);
    localparam logic [MCLK_W-1:0] SLOW_V = MCLK_W'(SLOW_CLK);

    logic in_window;

    always_comb begin
        in_window = !high_bank && (off >= FAST_LO) && (off <= FAST_HI);
        if (internal)       mclk = IO_V;
        else if (in_window) mclk = FAST_V;
        else                mclk = SLOW_V;
    end
endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
    import irq_entry_pkg::*;
(
    input  seq_state_e         state,
    input  logic               emu,
    input  logic [BANK_W-1:0]  pbank,
    input  logic [PC_W-1:0]    pc,
    input  logic [DATA_W-1:0]  psr,
    input  logic [PC_W-1:0]    sp,
    input  logic [PC_W-1:0]    vec,
    output logic [BANK_W-1:0]  bank,
    output logic [PC_W-1:0]    off,
    output logic [DATA_W-1:0]  dout,
    output logic               rwb,
    output bus_kind_e          kind
);
    logic [DATA_W-1:0] psr_stacked;

    always_comb begin
        psr_stacked = emu ? (psr & ~BRK_MASK) : psr;
        bank = pbank;
        off  = pc;
        dout = '0;
        rwb  = 1'b1;
        kind = K_INTERNAL;
        unique case (state)
            S_DUMMY: kind = K_PROGRAM;
            S_IO:    kind = K_INTERNAL;
            S_PUSH_B, S_PUSH_H, S_PUSH_L, S_PUSH_P: begin
                bank = '0;
                off  = sp;
                rwb  = 1'b0;
                kind = K_DATA;
                case (state)
                    S_PUSH_B: dout = pbank;
                    S_PUSH_H: dout = pc[PC_W-1:DATA_W];
                    S_PUSH_L: dout = pc[DATA_W-1:0];
                    default:  dout = psr_stacked;
                endcase
            end
            S_VEC_L: begin
                bank = '0;
                off  = vec;
                kind = K_DATA;
            end
            S_VEC_H: begin
                bank = '0;
                off  = vec + 1'b1;
                kind = K_DATA;
            end
            default: kind = K_INTERNAL;
        endcase
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               emu_i,
    input  logic [BANK_W-1:0]  pbank_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [DATA_W-1:0]  psr_i,
    input  logic [PC_W-1:0]    sp_entry,
    input  logic [PC_W-1:0]    vec_i,
    input  logic [DATA_W-1:0]  din_i,
    input  logic [PC_W-1:0]    sp_dec,
    output seq_state_e         state,
    output logic               emu,
    output logic [BANK_W-1:0]  pbank,
    output logic [PC_W-1:0]    pc,
    output logic [DATA_W-1:0]  psr,
    output logic [PC_W-1:0]    sp,
    output logic [PC_W-1:0]    vec
);
    seq_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            S_IDLE: if (start_i) begin
                ctx_d.state = S_DUMMY;
                ctx_d.emu   = emu_i;
                ctx_d.pbank = pbank_i;
                ctx_d.pc    = pc_i;
                ctx_d.psr   = psr_i;
                ctx_d.sp    = sp_entry;
                ctx_d.vec   = vec_i;
            end
            S_DUMMY: ctx_d.state = S_IO;
            S_IO:    ctx_d.state = ctx_q.emu ? S_PUSH_H : S_PUSH_B;
            S_PUSH_B: begin
                ctx_d.state = S_PUSH_H;
                ctx_d.sp    = sp_dec;
            end
            S_PUSH_H: begin
                ctx_d.state = S_PUSH_L;
                ctx_d.sp    = sp_dec;
            end
            S_PUSH_L: begin
                ctx_d.state = S_PUSH_P;
                ctx_d.sp    = sp_dec;
            end
            S_PUSH_P: begin
                ctx_d.state = S_VEC_L;
                ctx_d.sp    = sp_dec;
            end
            S_VEC_L: begin
                ctx_d.state = S_VEC_H;
                ctx_d.vlo   = din_i;
                ctx_d.pbank = '0;
                ctx_d.psr   = (ctx_q.psr | IRQ_MASK) & ~DEC_MASK;
            end
            S_VEC_H: begin
                ctx_d.state = S_DONE;
                ctx_d.pc    = {din_i, ctx_q.vlo};
            end
            default: ctx_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{state: S_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign state = ctx_q.state;
    assign emu   = ctx_q.emu;
    assign pbank = ctx_q.pbank;
    assign pc    = ctx_q.pc;
    assign psr   = ctx_q.psr;
    assign sp    = ctx_q.sp;
    assign vec   = ctx_q.vec;

    // R9: a sequence opens only from idle
    p_open_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state != S_IDLE) |=> (ctx_q.state != S_DUMMY));

    // R7: bank and flags already updated during the second vector read
    p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state == S_VEC_H) |-> (ctx_q.pbank == '0 && ctx_q.psr[2] && !ctx_q.psr[3]));

    // R10: every native push lowers SP by one
    p_sp_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state inside {S_PUSH_B, S_PUSH_H, S_PUSH_L, S_PUSH_P} && !ctx_q.emu)
        |=> (ctx_q.sp == $past(ctx_q.sp) - 16'd1));

    // R4: emulation stack never leaves page one
    p_page_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.state != S_IDLE && ctx_q.emu) |-> (ctx_q.sp[PC_W-1:DATA_W] == 8'h01));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              IO_CLK   = 6,
    parameter int              FAST_CLK = 6,
    parameter int              SLOW_CLK = 8,
    parameter logic [15:0]     FAST_LO  = 16'h2000,
    parameter logic [15:0]     FAST_HI  = 16'h5FFF,
    parameter int              HIGH_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               emu_i,
    input  logic [7:0]         pbank_i,
    input  logic [15:0]        pc_i,
    input  logic [7:0]         psr_i,
    input  logic [15:0]        sp_i,
    input  logic [15:0]        vec_i,
    input  logic [7:0]         din_i,
    output logic [23:0]        addr_o,
    output logic [7:0]         dout_o,
    output logic               rwb_o,
    output logic               vda_o,
    output logic               vpa_o,
    output logic [3:0]         mclk_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [15:0]        pc_o,
    output logic [7:0]         pbank_o,
    output logic [7:0]         psr_o,
    output logic [15:0]        sp_o
);
    seq_state_e         state;
    logic               emu;
    logic [BANK_W-1:0]  pbank, bus_bank;
    logic [PC_W-1:0]    pc, sp, vec, sp_dec, sp_entry, bus_off;
    logic [DATA_W-1:0]  psr;
    bus_kind_e          kind;

    irq_entry_stack #(.W(PC_W), .PAGE(8'h01)) u_stack (
        .emu_cur (emu),
        .sp_cur  (sp),
        .emu_new (emu_i),
        .sp_new  (sp_i),
        .sp_dec  (sp_dec),
        .sp_entry(sp_entry)
    );

    irq_entry_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .emu_i   (emu_i),
        .pbank_i (pbank_i),
        .pc_i    (pc_i),
        .psr_i   (psr_i),
        .sp_entry(sp_entry),
        .vec_i   (vec_i),
        .din_i   (din_i),
        .sp_dec  (sp_dec),
        .state   (state),
        .emu     (emu),
        .pbank   (pbank),
        .pc      (pc),
        .psr     (psr),
        .sp      (sp),
        .vec     (vec)
    );

    irq_entry_bus u_bus (
        .state(state),
        .emu  (emu),
        .pbank(pbank),
        .pc   (pc),
        .psr  (psr),
        .sp   (sp),
        .vec  (vec),
        .bank (bus_bank),
        .off  (bus_off),
        .dout (dout_o),
        .rwb  (rwb_o),
        .kind (kind)
    );

    irq_entry_cost #(
        .PC_W    (PC_W),
        .MCLK_W  (MCLK_W),
        .IO_CLK  (IO_CLK),
        .FAST_CLK(FAST_CLK),
        .SLOW_CLK(SLOW_CLK),
        .FAST_LO (FAST_LO),
        .FAST_HI (FAST_HI)
    ) u_cost (
        .internal (kind == K_INTERNAL),
        .high_bank(bus_bank[HIGH_BIT]),
        .off      (bus_off),
        .mclk     (mclk_o)
    );

    assign addr_o  = {bus_bank, bus_off};
    assign vda_o   = kind[1];
    assign vpa_o   = kind[0];
    assign busy_o  = (state != S_IDLE);
    assign done_o  = (state == S_DONE);
    assign pc_o    = pc;
    assign pbank_o = pbank;
    assign psr_o   = psr;
    assign sp_o    = sp;

    // R3: writes only as data accesses
    p_write_is_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rwb_o |-> (vda_o && !vpa_o));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: internal cycles cost the I/O length
    p_io_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !vda_o && !vpa_o) |-> (mclk_o == 4'(IO_CLK)));

    // R1: idle bus is a quiet read
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rwb_o && !vda_o && !vpa_o && !done_o));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        emu_i = 1'b0;
    logic [7:0]  pbank_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  psr_i = '0;
    logic [15:0] sp_i = '0;
    logic [15:0] vec_i = '0;
    logic [7:0]  din_i;
    logic [23:0] addr_o;
    logic [7:0]  dout_o;
    logic        rwb_o, vda_o, vpa_o, busy_o, done_o;
    logic [3:0]  mclk_o;
    logic [15:0] pc_o, sp_o;
    logic [7:0]  pbank_o, psr_o;

    int total = 0;
    int bad   = 0;

    // memory model for vector reads
    logic [15:0] m_vec = '0;
    logic [7:0]  m_lo = '0, m_hi = '0;
    logic [15:0] m_vec1;
    assign m_vec1 = m_vec + 16'd1;
    assign din_i = (addr_o == {8'h00, m_vec})  ? m_lo :
                   (addr_o == {8'h00, m_vec1}) ? m_hi : 8'h5A;

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .emu_i(emu_i),
        .pbank_i(pbank_i), .pc_i(pc_i), .psr_i(psr_i), .sp_i(sp_i),
        .vec_i(vec_i), .din_i(din_i), .addr_o(addr_o), .dout_o(dout_o),
        .rwb_o(rwb_o), .vda_o(vda_o), .vpa_o(vpa_o), .mclk_o(mclk_o),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .pbank_o(pbank_o),
        .psr_o(psr_o), .sp_o(sp_o)
    );

    // {emu, pbank, pc, psr, sp, vec, lo, hi}
    localparam logic [87:0] SCN [6] = '{
        {8'h00, 8'h00, 16'h8100, 8'h30, 16'h01FF, 16'hFFEE, 8'h34, 8'h12},
        {8'h01, 8'h00, 16'h2100, 8'hFF, 16'h01FF, 16'hFFFE, 8'h00, 8'h90},
        {8'h01, 8'h00, 16'hC000, 8'h10, 16'h0501, 16'hFFFA, 8'hCD, 8'hAB},
        {8'h00, 8'h7E, 16'h3000, 8'h08, 16'h0002, 16'hFFEA, 8'h78, 8'h56},
        {8'h00, 8'h81, 16'h4000, 8'h00, 16'h3000, 16'hFFFF, 8'h11, 8'h22},
        {8'h01, 8'h12, 16'h5FFF, 8'h14, 16'h01A0, 16'h2000, 8'hEF, 8'hBE}
    };

    function automatic logic [3:0] cost(input logic [23:0] a, input logic internal);
        if (internal) return 4'd6;
        if (!a[22] && a[15:0] >= 16'h2000 && a[15:0] <= 16'h5FFF) return 4'd6;
        return 4'd8;
    endfunction

    function automatic logic [15:0] sp_less(input logic [15:0] s, input logic e);
        logic [7:0] lo;
        lo = s[7:0] - 8'd1;
        return e ? {8'h01, lo} : (s - 16'd1);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bus(input string req, input logic [23:0] ea, input logic er,
                             input logic ev, input logic ep, input logic [7:0] ed);
        logic [3:0] em;
        em = cost(ea, !ev && !ep);
        if (!er)
            check(req, {24'h0, addr_o, dout_o, rwb_o, vda_o, vpa_o, mclk_o},
                       {24'h0, ea, ed, er, ev, ep, em});
        else
            check(req, {32'h0, addr_o, rwb_o, vda_o, vpa_o, mclk_o},
                       {32'h0, ea, er, ev, ep, em});
    endtask

    task automatic run_scn(input logic [87:0] s);
        logic        e;
        logic [7:0]  pb, ps, lo, hi, pst, pfin;
        logic [15:0] pc, sp, vec, cur;
        e = s[80]; pb = s[79:72]; pc = s[71:56]; ps = s[55:48];
        sp = s[47:32]; vec = s[31:16]; lo = s[15:8]; hi = s[7:0];
        @(negedge clk);
        emu_i = e; pbank_i = pb; pc_i = pc; psr_i = ps; sp_i = sp; vec_i = vec;
        m_vec = vec; m_lo = lo; m_hi = hi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_bus("R2 dummy read", {pb, pc}, 1'b1, 1'b0, 1'b1, 8'h00);
        @(negedge clk);
        check_bus("R2 internal", {pb, pc}, 1'b1, 1'b0, 1'b0, 8'h00);
        cur = e ? {8'h01, sp[7:0]} : sp;
        if (!e) begin
            @(negedge clk);
            check_bus("R3 push bank", {8'h00, cur}, 1'b0, 1'b1, 1'b0, pb);
            cur = sp_less(cur, e);
        end
        @(negedge clk);
        check_bus(e ? "R4 push pch" : "R3 push pch", {8'h00, cur}, 1'b0, 1'b1, 1'b0, pc[15:8]);
        cur = sp_less(cur, e);
        @(negedge clk);
        check_bus(e ? "R4 push pcl" : "R3 push pcl", {8'h00, cur}, 1'b0, 1'b1, 1'b0, pc[7:0]);
        cur = sp_less(cur, e);
        @(negedge clk);
        pst = e ? (ps & 8'hEF) : ps;
        check_bus("R5 push status", {8'h00, cur}, 1'b0, 1'b1, 1'b0, pst);
        cur = sp_less(cur, e);
        @(negedge clk);
        check_bus("R6 vector low", {8'h00, vec}, 1'b1, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check_bus("R6 vector high", {8'h00, vec + 16'd1}, 1'b1, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check("R6 done and pc", {46'h0, done_o, busy_o, pc_o}, {46'h0, 1'b1, 1'b1, hi, lo});
        pfin = (ps | 8'h04) & 8'hF7;
        check("R7 bank and flags", {48'h0, pbank_o, psr_o}, {48'h0, 8'h00, pfin});
        check("R10 final sp", {48'h0, sp_o}, {48'h0, cur});
        @(negedge clk);
        check("R6 pulse ends", {62'h0, done_o, busy_o}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 in reset", {59'h0, busy_o, done_o, rwb_o, vda_o, vpa_o},
                             {59'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {59'h0, busy_o, done_o, rwb_o, vda_o, vpa_o},
                                {59'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

        for (int i = 0; i < 6; i++) run_scn(SCN[i]);

        // R9: request held high across the whole sequence with other inputs
        @(negedge clk);
        emu_i = 1'b0; pbank_i = 8'h00; pc_i = 16'h8100; psr_i = 8'h30;
        sp_i = 16'h01FF; vec_i = 16'hFFEE; m_vec = 16'hFFEE; m_lo = 8'h34; m_hi = 8'h12;
        start_i = 1'b1;
        @(negedge clk);
        pc_i = 16'hAAAA; emu_i = 1'b1; vec_i = 16'h1234;
        repeat (3) @(negedge clk);
        check("R9 push keeps first pc", {56'h0, dout_o}, {56'h0, 8'h81});
        repeat (5) @(negedge clk);
        check("R9 done with first vector", {47'h0, done_o, pc_o}, {47'h0, 1'b1, 16'h1234});
        @(negedge clk);
        check("R9 no restart from done", {63'h0, busy_o}, 64'h0);
        start_i = 1'b0;
        @(negedge clk);
        check("R9 stays idle", {63'h0, busy_o}, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule